// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is a single-master I2C controller that a processor steers one byte at a time. Software loads a byte into the data register. It then writes a command word to the control register. That command moves exactly one byte, plus its acknowledge slot, over the open-drain SCL and SDA lines. Three qualifier bits in the command frame the byte:

- a start bit puts a START (or a repeated START) in front of the byte;
- a stop bit puts a STOP after the acknowledge slot;
- a nak bit makes the master leave the acknowledge slot released on a received byte.

Software reads the status register to learn that the byte has finished, whether the acknowledge slot was low, and whether a received byte is waiting in the data register. The direction of every byte that follows an address byte comes from that address byte's least significant bit.

SCL is derived from the peripheral clock. The high part of each SCL bit lasts DIV+2 clocks. The low part lasts DIV+2+GSR clocks. The full bit period is therefore 2*(DIV+2)+GSR clocks. The lines are modelled as output enables that pull low. SDA is sampled through a two-stage synchronizer.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status register (offset 1) reads 0, neither line is pulled low, the divider (offset 3) reads 0, and the timing register (offset 4) reads 32 in its setup/hold field at bits [23:16] and 0 in its glitch field at bits [3:0].
- R2: With divider value DIV and glitch value GSR, consecutive SCL rising edges inside a byte are 2*(DIV+2)+GSR clock cycles apart.
- R3: A command with start bit (control bit 2) set produces a START before the byte when the bus is free. It produces a repeated START (SDA released, SCL raised, then SDA pulled low) when the bus is still held from an earlier byte. SDA changes while SCL is released only to form a START or STOP.
- R4: A transmitted byte goes out MSB first and SDA is released in the ninth slot. Status bit 3 then holds the SDA level sampled there (1 means no acknowledge).
- R5: With stop bit (control bit 3) set, a STOP follows the acknowledge slot and both lines end released. Without it, SCL stays pulled low after the byte.
- R6: After a start-qualified byte whose bit 0 was 1, later commands without a start bit receive a byte. After a start-qualified byte whose bit 0 was 0, they transmit.
- R7: A received byte lands in the data register (offset 2) and sets status bit 2. The master pulls the ninth slot low unless nak bit (control bit 4) is set, in which case it leaves SDA released.
- R8: Status bit 1 sets when a transmitted byte's acknowledge slot ends. Status bits 1 and 2 both clear when a new command is accepted, and are never set together.
- R9: A command (control bits 0 and 1 both set) makes status bit 0 read 1 until the byte, its acknowledge slot and any STOP are done. Control writes made while busy without bit 7 are ignored.
- R10: Writing control bit 7 aborts any transfer, releases both lines and clears the status flags. Bit 7 reads back 0 once the reset is done, and the divider and timing registers keep their values.
- R11: Writes to the timing register store the glitch field at bits [3:0] and the setup/hold field at bits [23:16], and both read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write register offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read register offset |
| reg_rdata | output | 32 | Read data for reg_raddr |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |

## Verification
The bench builds the block with its default widths: an 18-bit divider, a 4-bit glitch field and an 8-bit setup/hold field with reset value 32. It programs divider values of 3 and 1 with glitch values of 2 and 0. Those settings make each SCL bit 12 and 6 clocks long, so complete write, repeated-START read, missing-acknowledge and abort sequences each finish within a few hundred cycles. Because the two settings differ in both fields, the measured period shows separately whether the divider term and the glitch term enter the law.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_W   = 18,
  parameter int GSR_W   = 4,
  parameter int TSR_W   = 8,
  parameter int TSR_RST = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [2:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int TW = DIV_W + 1;

  typedef enum logic [3:0] {IDLE, RS_LO, RS_HI, S_HOLD, B_LO, B_HI, P_LO, P_HI, P_END} st_t;
  st_t st;

  logic [TW-1:0]    tmr;
  logic [DIV_W-1:0] div_q;
  logic [GSR_W-1:0] gsr_q;
  logic [TSR_W-1:0] tsr_q;
  logic [7:0]       data_q, sh;
  logic [3:0]       bitn;
  logic rx_q, rd_dir, start_q, stop_q, nak_q, held, dt, dr, nack, srst_q, sda_s1, sda_s2;

  wire busy    = st != IDLE;
  wire ctrl_we = reg_we && reg_waddr == 3'd0;
  wire cmd_ok  = ctrl_we && !busy && !srst_q && reg_wdata[0] && reg_wdata[1] && !reg_wdata[7];
  wire [TW-1:0] h_len = TW'(div_q) + TW'(2);
  wire [TW-1:0] l_len = h_len + TW'(gsr_q);
  wire lo_ph = st == RS_LO || st == B_LO || st == P_LO;
  wire tick  = tmr == (lo_ph ? l_len : h_len) - TW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      gsr_q <= '0;
      tsr_q <= TSR_W'(TSR_RST);
    end else if (reg_we) begin
      if (reg_waddr == 3'd3) div_q <= reg_wdata[DIV_W-1:0];
      if (reg_waddr == 3'd4) begin
        gsr_q <= reg_wdata[GSR_W-1:0];
        tsr_q <= reg_wdata[16 +: TSR_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_s1 <= 1'b1;
      sda_s2 <= 1'b1;
    end else begin
      sda_s1 <= sda_in;
      sda_s2 <= sda_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; tmr <= '0; data_q <= '0; sh <= '0; bitn <= '0;
      rx_q <= 1'b0; rd_dir <= 1'b0; start_q <= 1'b0; stop_q <= 1'b0; nak_q <= 1'b0;
      held <= 1'b0; dt <= 1'b0; dr <= 1'b0; nack <= 1'b0; srst_q <= 1'b0;
    end else if (srst_q) begin
      st <= IDLE; tmr <= '0; held <= 1'b0; rd_dir <= 1'b0;
      dt <= 1'b0; dr <= 1'b0; nack <= 1'b0; srst_q <= 1'b0;
    end else begin
      if (ctrl_we && reg_wdata[7]) srst_q <= 1'b1;
      if (reg_we && reg_waddr == 3'd2) data_q <= reg_wdata[7:0];
      if (st == IDLE) begin
        if (cmd_ok) begin
          dt <= 1'b0; dr <= 1'b0; tmr <= '0; bitn <= '0; sh <= data_q;
          start_q <= reg_wdata[2]; stop_q <= reg_wdata[3]; nak_q <= reg_wdata[4];
          rx_q <= reg_wdata[2] ? 1'b0 : rd_dir;
          st <= !reg_wdata[2] ? B_LO : (held ? RS_LO : S_HOLD);
        end
      end else if (!tick) begin
        tmr <= tmr + TW'(1);
      end else begin
        tmr <= '0;
        case (st)
          RS_LO:  st <= RS_HI;
          RS_HI:  st <= S_HOLD;
          S_HOLD: begin st <= B_LO; held <= 1'b1; end
          B_LO:   st <= B_HI;
          B_HI: if (bitn == 4'd8) begin
            nack <= sda_s2;
            if (rx_q) begin dr <= 1'b1; data_q <= sh; end
            else dt <= 1'b1;
            if (start_q) rd_dir <= data_q[0];
            st <= stop_q ? P_LO : IDLE;
          end else begin
            bitn <= bitn + 4'd1;
            sh   <= {sh[6:0], sda_s2};
            st   <= B_LO;
          end
          P_LO:   st <= P_HI;
          P_HI:   st <= P_END;
          P_END:  begin st <= IDLE; held <= 1'b0; end
          default: st <= IDLE;
        endcase
      end
    end
  end

  assign scl_oe = lo_ph || (st == IDLE && held);

  always_comb begin
    case (st)
      S_HOLD, P_LO, P_HI: sda_oe = 1'b1;
      B_LO, B_HI:         sda_oe = bitn[3] ? (rx_q && !nak_q) : (!rx_q && !sh[7]);
      default:            sda_oe = 1'b0;
    endcase
  end

  always_comb begin
    case (reg_raddr)
      3'd0:    reg_rdata = {24'd0, srst_q, 7'd0};
      3'd1:    reg_rdata = {28'd0, nack, dr, dt, busy};
      3'd2:    reg_rdata = {24'd0, data_q};
      3'd3:    reg_rdata = 32'(div_q);
      3'd4:    reg_rdata = (32'(tsr_q) << 16) | 32'(gsr_q);
      default: reg_rdata = 32'd0;
    endcase
  end

  // R3
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)) && !$past(srst_q))
      |-> (st == S_HOLD || st == P_END));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !srst_q) |=> ($stable(stop_q) && $stable(nak_q) && $stable(rx_q)));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(dt && dr));

  // R8
  dt_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dt) |-> ($past(st) == B_HI && bitn == 4'd8));

  // R10
  srst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!srst_q && !busy && !scl_oe && !sda_oe));
endmodule

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        scl_oe, sda_oe;
  logic        tgt_drive = 1'b0;
  wire         sda_line = !(sda_oe || tgt_drive);
  wire         scl_line = !scl_oe;

  always #5 clk = ~clk;

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line));

  localparam logic [1:0] EV_S = 2'd1, EV_P = 2'd2, EV_B = 2'd3;
  localparam logic [31:0] C_EN = 32'h3, C_ST = 32'h4, C_SP = 32'h8, C_NK = 32'h10, C_RST = 32'h80;

  int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
  int cyc = 0, rise1 = 0, last_per = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];
  logic        mon_en = 1'b1;
  logic        tgt_rd = 1'b0, tgt_ack = 1'b1, tgt_off = 1'b0;
  logic [7:0]  tgt_byte = 8'h00;
  int          nbits = 0, tgt_cnt = 0;
  logic [8:0]  msh = '0;
  logic        p_scl = 1'b1, p_sda = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [10:0] ev(input logic [1:0] k, input logic [7:0] b, input logic a);
    return {k, b, a};
  endfunction

  task automatic expect_ev(input logic [10:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [10:0] e);
    logic [10:0] x;
    string t;
    if (!mon_en) return;
    mon_checks++;
    if (exp_q.size() == 0) begin
      mon_fails++;
      $display("FAIL bus event unexpected: actual %h expected none", e);
    end else begin
      x = exp_q.pop_front();
      t = tag_q.pop_front();
      if (x !== e) begin
        mon_fails++;
        $display("FAIL %s bus event: actual %h expected %h", t, e, x);
      end
    end
  endtask

  // monitor and target model, sampled away from the active edge
  always @(negedge clk) begin
    if (p_scl && scl_line && p_sda && !sda_line) begin
      observe(ev(EV_S, 8'h00, 1'b0));
      nbits = 0; tgt_cnt = 0; tgt_off = 1'b0;
    end else if (p_scl && scl_line && !p_sda && sda_line) begin
      observe(ev(EV_P, 8'h00, 1'b0));
    end
    if (!p_scl && scl_line) begin
      msh = {msh[7:0], sda_line};
      nbits = nbits + 1;
      if (nbits == 1) rise1 = cyc;
      if (nbits == 2) last_per = cyc - rise1;
      if (nbits == 9) begin
        if (tgt_rd && sda_line) tgt_off = 1'b1;
        observe(ev(EV_B, msh[8:1], msh[0]));
        nbits = 0;
      end
    end
    if (p_scl && !scl_line) tgt_cnt = nbits;
    tgt_drive = !tgt_off && (tgt_rd ? (tgt_cnt < 8 && !tgt_byte[7 - tgt_cnt])
                                    : (tgt_cnt == 8 && tgt_ack));
    p_scl = scl_line;
    p_sda = sda_line;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_raddr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd1, v);
      if (!v[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic [31:0] ctl);
    wr(3'd2, {24'd0, b});
    wr(3'd0, ctl);
    wait_idle();
  endtask

  task automatic summary();
    int tot, bad;
    tot = checks + mon_checks;
    bad = fails + mon_fails;
    $display("%0d/%0d checks passed", tot - bad, tot);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd1, v); check(v == 0, "R1 status", v, 0);
    check(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
    rd(3'd3, v); check(v == 0, "R1 divider", v, 0);
    rd(3'd4, v); check(v == 32'd32 << 16, "R1 timing", v, 32'd32 << 16);

    wr(3'd3, 32'd3);
    wr(3'd4, (32'd40 << 16) | 32'd2);
    rd(3'd4, v); check(v == ((32'd40 << 16) | 32'd2), "R11 timing readback", v, (32'd40 << 16) | 32'd2);

    // write transaction
    expect_ev(ev(EV_S, 8'h00, 1'b0), "R3");
    expect_ev(ev(EV_B, 8'hA0, 1'b0), "R4");
    wr(3'd2, 32'hA0);
    wr(3'd0, C_EN | C_ST);
    rd(3'd1, v); check(v[0] == 1'b1, "R9 busy", v, 1);
    wait_idle();
    rd(3'd1, v); check(v == 32'h2, "R8 tx done", v, 32'h2);
    check(scl_oe == 1'b1, "R5 scl held", scl_oe, 1);
    check(last_per == 12, "R2 period 12", last_per, 12);

    expect_ev(ev(EV_B, 8'h3C, 1'b0), "R4");
    wr(3'd2, 32'h3C);
    wr(3'd0, C_EN);
    rd(3'd1, v); check(v[1] == 1'b0, "R8 flag clear", v, 32'h1);
    wr(3'd0, C_EN | C_SP);
    wait_idle();
    check(scl_oe == 1'b1, "R9 ignored stop", scl_oe, 1);

    expect_ev(ev(EV_B, 8'h5A, 1'b0), "R4");
    expect_ev(ev(EV_P, 8'h00, 1'b0), "R5");
    send(8'h5A, C_EN | C_SP);
    check(!scl_oe && !sda_oe, "R5 released", {scl_oe, sda_oe}, 0);
    rd(3'd1, v); check(v == 32'h2, "R8 after stop", v, 32'h2);

    // read transaction with repeated start
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd0);
    expect_ev(ev(EV_S, 8'h00, 1'b0), "R3");
    expect_ev(ev(EV_B, 8'hA0, 1'b0), "R4");
    expect_ev(ev(EV_B, 8'h10, 1'b0), "R4");
    expect_ev(ev(EV_S, 8'h00, 1'b0), "R3 repeated");
    expect_ev(ev(EV_B, 8'hA1, 1'b0), "R6");
    expect_ev(ev(EV_B, 8'hC5, 1'b0), "R7 ack");
    expect_ev(ev(EV_B, 8'h3E, 1'b1), "R7 nak");
    expect_ev(ev(EV_P, 8'h00, 1'b0), "R5");
    send(8'hA0, C_EN | C_ST);
    send(8'h10, C_EN);
    send(8'hA1, C_EN | C_ST);
    check(last_per == 6, "R2 period 6", last_per, 6);
    tgt_byte = 8'hC5; tgt_rd = 1'b1;
    wr(3'd0, C_EN);
    wait_idle();
    rd(3'd1, v); check(v == 32'h4, "R7 rx ready", v, 32'h4);
    rd(3'd2, v); check(v == 32'hC5, "R6 rx data", v, 32'hC5);
    tgt_byte = 8'h3E;
    wr(3'd0, C_EN | C_NK | C_SP);
    wait_idle();
    rd(3'd1, v); check(v == 32'hC, "R7 nak status", v, 32'hC);
    rd(3'd2, v); check(v == 32'h3E, "R7 last data", v, 32'h3E);
    tgt_rd = 1'b0;

    // missing acknowledge
    tgt_ack = 1'b0;
    expect_ev(ev(EV_S, 8'h00, 1'b0), "R3");
    expect_ev(ev(EV_B, 8'hA4, 1'b1), "R4");
    expect_ev(ev(EV_P, 8'h00, 1'b0), "R5");
    send(8'hA4, C_EN | C_ST | C_SP);
    rd(3'd1, v); check(v == 32'hA, "R4 no ack", v, 32'hA);
    tgt_ack = 1'b1;

    // abort by soft reset
    mon_en = 1'b0;
    wr(3'd2, 32'hFF);
    wr(3'd0, C_EN | C_ST);
    repeat (20) @(negedge clk);
    wr(3'd0, C_RST);
    @(negedge clk);
    rd(3'd0, v); check(v == 0, "R10 bit clears", v, 0);
    rd(3'd1, v); check(v == 0, "R10 status", v, 0);
    check(!scl_oe && !sda_oe, "R10 lines", {scl_oe, sda_oe}, 0);
    rd(3'd3, v); check(v == 1, "R10 divider kept", v, 1);
    repeat (10) @(negedge clk);
    mon_en = 1'b1;
    expect_ev(ev(EV_S, 8'h00, 1'b0), "R10");
    expect_ev(ev(EV_B, 8'hA0, 1'b0), "R10");
    expect_ev(ev(EV_P, 8'h00, 1'b0), "R10");
    send(8'hA0, C_EN | C_ST | C_SP);
    rd(3'd1, v); check(v == 32'h2, "R10 works after", v, 32'h2);

    repeat (50) @(negedge clk);
    check(exp_q.size() == 0, "R3 all events seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule